// File: doc/BRIEF.md
# SRTS Time Stamp Generator (Transmit Side)

This block builds the residual time stamp that a circuit-emulation transmitter sends to its far end. The block has no service clock input. It makes a service-clock tick stream from a fixed backplane bus clock. A phase accumulator adds the number of TDM channels carried by the virtual circuit on every bus-clock strobe. It issues one tick each time the sum passes a wrap value, and the wrap value is set by the bus rate. The result is a tick rate of channels × 64 kHz on average, including channel counts that do not divide evenly.

The network reference clock arrives asynchronously. The fast master clock samples it through a synchronizer, and each rising edge advances a small free-running counter. When a fixed number of service ticks have passed, the low bits of that counter are captured as the time stamp. The captured value is moved to a transmit register only when a cell with sequence count 0 is requested. The value is then sent one bit per odd-numbered cell on the CSI output, which is valid in the same cycle as the cell request.

Top module: `srts_stamp_gen`

## Requirements
- R1: The wrap value is 32 for rateSel 0 (2.048 MHz bus), 64 for rateSel 1 (4.096 MHz) and 128 for rateSel 2 or 3 (8.192 MHz). Each busTick adds chanCount to the accumulator. A service tick is issued on every busTick where the sum reaches the wrap value, and the wrap value is then subtracted.
- R2: A measurement period ends on the PERIOD_TICKS-th service tick (3008 by default). After reset, period p therefore ends on busTick number ceil(p × PERIOD_TICKS × wrap / chanCount).
- R3: netClkIn passes through two synchronizer flops in the master domain. Each rising edge is counted exactly once, provided that the high and low phases each last at least three master cycles.
- R4: At the end of each period, the count of network-clock rising edges since reset, modulo 16, is captured as the 4-bit time stamp.
- R5: While a stamp is being sent, the CSI output for a requested cell carries the stamp bits MSB first. Sequence 1 carries bit 3, sequence 3 carries bit 2, sequence 5 carries bit 1 and sequence 7 carries bit 0.
- R6: csiOut is 0 for cells with an even sequence count and whenever cellReq is low.
- R7: A newly captured stamp moves to the transmit register only on a cellReq with seqCount 0. A cycle of 8 cells that is already in progress keeps sending the old stamp to its end.
- R8: After the synchronous reset, csiOut stays 0 until a period has completed and a sequence-0 request has followed it.
- R9: chanCount must lie between 1 and the wrap value selected by rateSel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| busTick | input | 1 | One-cycle strobe per TDM bus clock period |
| rateSel | input | 2 | Bus rate: 0 = 2.048, 1 = 4.096, 2/3 = 8.192 MHz |
| chanCount | input | CHAN_W | TDM channels carried by the VC |
| netClkIn | input | 1 | Divided network reference clock, asynchronous |
| cellReq | input | 1 | Cell header request strobe |
| seqCount | input | 3 | Sequence count of the requested cell |
| csiOut | output | 1 | CSI bit for the requested cell, same cycle |

## Verification
csiOut is combinational from cellReq and seqCount, so the bench drives each request on a falling edge and compares csiOut two nanoseconds later in the same cycle. The capture at the end of a period takes effect at the rising edge of the cycle holding the final busTick. Every cell run is therefore started on a later falling edge. A network-clock edge needs three master edges before it reaches the counter, so each burst of pulses is followed by idle cycles before any busTick that could end a period. The bench computes the busTick on which each period ends from the ceiling formula in R2, then checks that no stamp appears one tick earlier and that the stamp appears right after that tick.

// File: rtl/srts_pkg.sv
package srts_pkg;
  localparam int RTS_W = 4;
  localparam int SEQ_W = 3;

  typedef struct packed {
    logic svcTick;
    logic periodEnd;
    logic loadTx;
  } srtsStrobe_t;
endpackage

// File: rtl/srts_ctrl.sv
module srts_ctrl
  import srts_pkg::*;
#(
  parameter int CHAN_W       = 8,
  parameter int BASE_WRAP    = 32,
  parameter int PERIOD_TICKS = 3008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busTick,
  input  logic [1:0]        rateSel,
  input  logic [CHAN_W-1:0] chanCount,
  input  logic              cellReq,
  input  logic [SEQ_W-1:0]  seqCount,
  output srtsStrobe_t       strobe
);
  localparam int MAX_WRAP = BASE_WRAP * 4;
  localparam int ACC_W    = $clog2(MAX_WRAP + (1 << CHAN_W));
  localparam int PER_W    = $clog2(PERIOD_TICKS + 1);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accSum;
  logic [ACC_W-1:0] wrapVal;
  logic [1:0]       rateShift;
  logic [PER_W-1:0] perCnt;
  logic             crossing;
  logic             lastTick;

  always_comb begin
    rateShift = (rateSel == 2'd3) ? 2'd2 : rateSel;
    wrapVal   = ACC_W'(BASE_WRAP) << rateShift;
    accSum    = acc + ACC_W'(chanCount);
    crossing  = busTick && (accSum >= wrapVal);
    lastTick  = (perCnt == PER_W'(PERIOD_TICKS - 1));
    strobe.svcTick   = crossing;
    strobe.periodEnd = crossing && lastTick;
    strobe.loadTx    = cellReq && (seqCount == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      perCnt <= '0;
    end else begin
      if (busTick) acc <= crossing ? accSum - wrapVal : accSum;
      if (crossing) perCnt <= lastTick ? '0 : perCnt + PER_W'(1);
    end
  end

  assert_acc_below_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    acc < wrapVal);
  assert_acc_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !busTick |=> $stable(acc));
  assert_period_bound_R2: assert property (@(posedge clk) disable iff (rst)
    perCnt < PER_W'(PERIOD_TICKS));
  assert_chan_range_R9: assert property (@(posedge clk) disable iff (rst)
    (chanCount != '0) && (ACC_W'(chanCount) <= wrapVal));
endmodule

// File: rtl/srts_dp.sv
module srts_dp
  import srts_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             netClkIn,
  input  srtsStrobe_t      strobe,
  input  logic             cellReq,
  input  logic [SEQ_W-1:0] seqCount,
  output logic             csiOut
);
  logic             syncA, syncB, syncPrev;
  logic             netRise;
  logic [RTS_W-1:0] edgeCnt;
  logic [RTS_W-1:0] heldRts;
  logic             heldValid;
  logic [RTS_W-1:0] txRts;
  logic             txValid;
  logic [1:0]       bitSel;

  assign netRise = syncB && !syncPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA     <= 1'b0;
      syncB     <= 1'b0;
      syncPrev  <= 1'b0;
      edgeCnt   <= '0;
      heldRts   <= '0;
      heldValid <= 1'b0;
      txRts     <= '0;
      txValid   <= 1'b0;
    end else begin
      syncA    <= netClkIn;
      syncB    <= syncA;
      syncPrev <= syncB;
      if (netRise) edgeCnt <= edgeCnt + RTS_W'(1);
      if (strobe.periodEnd) begin
        heldRts   <= edgeCnt;
        heldValid <= 1'b1;
      end
      if (strobe.loadTx) begin
        txRts   <= heldRts;
        txValid <= heldValid;
      end
    end
  end

  always_comb begin
    bitSel = ~seqCount[2:1];
    csiOut = cellReq && seqCount[0] && txValid && txRts[bitSel];
  end

  assert_edge_step_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (edgeCnt == $past(edgeCnt)) || (edgeCnt == $past(edgeCnt) + RTS_W'(1)));
  assert_capture_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !strobe.periodEnd |=> $stable(heldRts));
  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadTx |=> $stable(txRts) && $stable(txValid));
  assert_even_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (!cellReq || !seqCount[0]) |-> !csiOut);
  assert_quiet_start_R8: assert property (@(posedge clk) disable iff (rst)
    !txValid |-> !csiOut);
endmodule

// File: rtl/srts_stamp_gen.sv
module srts_stamp_gen
  import srts_pkg::*;
#(
  parameter int CHAN_W       = 8,
  parameter int BASE_WRAP    = 32,
  parameter int PERIOD_TICKS = 3008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busTick,
  input  logic [1:0]        rateSel,
  input  logic [CHAN_W-1:0] chanCount,
  input  logic              netClkIn,
  input  logic              cellReq,
  input  logic [2:0]        seqCount,
  output logic              csiOut
);
  srtsStrobe_t strobe;

  srts_ctrl #(
    .CHAN_W(CHAN_W), .BASE_WRAP(BASE_WRAP), .PERIOD_TICKS(PERIOD_TICKS)
  ) uCtrl (
    .clk(clk), .rst(rst), .busTick(busTick), .rateSel(rateSel),
    .chanCount(chanCount), .cellReq(cellReq), .seqCount(seqCount),
    .strobe(strobe)
  );

  srts_dp uDp (
    .clk(clk), .rst(rst), .netClkIn(netClkIn), .strobe(strobe),
    .cellReq(cellReq), .seqCount(seqCount), .csiOut(csiOut)
  );
endmodule

// File: tb/srts_stamp_gen_test.sv
module srts_stamp_gen_test;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busTick = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic [7:0] chanCount = 8'd1;
  logic netClkIn = 1'b0;
  logic cellReq = 1'b0;
  logic [2:0] seqCount = 3'd0;
  logic csiOut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  srts_stamp_gen #(.PERIOD_TICKS(P)) uut (
    .clk(clk), .rst(rst), .busTick(busTick), .rateSel(rateSel),
    .chanCount(chanCount), .netClkIn(netClkIn), .cellReq(cellReq),
    .seqCount(seqCount), .csiOut(csiOut)
  );

  task automatic check(input logic act, input logic exp, input string req, input int seq);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s seq=%0d actual=%0b expected=%0b", req, seq, act, exp);
    end
  endtask

  // Drive cells firstSeq..lastSeq; when valid, expect stamp bits (R5), else all zero (R8)
  task automatic cells(input int firstSeq, input int lastSeq, input logic valid,
                       input logic [3:0] stamp, input string req);
    for (int s = firstSeq; s <= lastSeq; s++) begin
      @(negedge clk);
      cellReq = 1'b1;
      seqCount = 3'(s);
      #2;
      if (!valid) check(csiOut, 1'b0, req, s);
      else if (s % 2 == 0) check(csiOut, 1'b0, "R6", s);
      else check(csiOut, stamp[3 - s / 2], req, s);
    end
    @(negedge clk);
    cellReq = 1'b0;
    #2 check(csiOut, 1'b0, "R6", -1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); busTick = 1'b1;
      @(negedge clk); busTick = 1'b0;
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); netClkIn = 1'b1;
      repeat (3) @(negedge clk);
      netClkIn = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  function automatic int endTick(input int p, input int wrap, input int c);
    return (p * P * wrap + c - 1) / c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int chans[4] = '{1, 7, 24, 32};
    for (int r = 0; r < 3; r++) begin
      for (int ci = 0; ci < 4; ci++) begin
        int wrap, c, n1, n2, k1, k2;
        logic [3:0] st1, st2;
        wrap = 32 << r;
        c = chans[ci];
        n1 = (c * 3 + r * 5) % 23 + 3;
        n2 = (c + r) % 11 + 1;
        st1 = 4'(n1);
        st2 = 4'(n1 + n2);
        k1 = endTick(1, wrap, c);
        k2 = endTick(2, wrap, c);
        @(negedge clk);
        rst = 1'b1; rateSel = 2'(r); chanCount = 8'(c);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state, nothing sent yet
        cells(0, 7, 1'b0, 4'd0, "R8");
        pulses(n1);
        // R2/R1: one busTick short of the first period end, still quiet
        ticks(k1 - 1);
        cells(0, 7, 1'b0, 4'd0, "R2");
        ticks(1);
        // R4/R3: captured edge count mod 16, sent MSB first (R5)
        cells(0, 7, 1'b1, st1, "R4");
        pulses(n2);
        // R7: start a cycle, finish the next period mid-cycle, old stamp kept
        cells(0, 3, 1'b1, st1, "R7");
        ticks(k2 - k1);
        cells(4, 7, 1'b1, st1, "R7");
        // R3/R4: cumulative count after the next seq-0 boundary (R1 rate via k2)
        cells(0, 7, 1'b1, st2, "R1");
      end
    end
    // rateSel 3 behaves as the 8.192 MHz setting (R1)
    @(negedge clk);
    rst = 1'b1; rateSel = 2'd3; chanCount = 8'd96;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    pulses(5);
    ticks(endTick(1, 128, 96) - 1);
    cells(0, 7, 1'b0, 4'd0, "R1");
    ticks(1);
    cells(0, 7, 1'b1, 4'd5, "R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule